// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block decides when a small 8-bit CPU core should take an interrupt, and which one. There are three sources: a timebase overflow and two sampling-rate counter overflows. An 8-bit control word holds a global enable, one enable per source, one pending flag per source and an inhibit bit for the timebase. The CPU reads and writes this word over a simple write-strobe port. The counters pulse overflow inputs. Each pulse sets its pending flag, whether or not interrupts are enabled.

The pending requests are checked only on the cycle marked by the `t2_rise` phase strobe. A request that is enabled, and that finds the stack not full on that cycle, raises `call_req` together with a fixed vector. The call stays posted until the CPU acknowledges it. The acknowledge clears the source's flag and the global enable, so a second interrupt cannot nest unless software allows it. A return-from-interrupt strobe sets the global enable again. A plain return has no strobe and leaves it unchanged. Saving registers, pushing the program counter and the stack itself belong to the CPU.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x00, `call_req` is 0 and `call_vec` is 0x00.
- R2: Bit layout of the control word: bit 0 global enable; bit 1 timebase enable; bit 2 sampler-1 enable; bit 3 sampler-2 enable; bit 4 timebase flag; bit 5 sampler-1 flag; bit 6 sampler-2 flag; bit 7 timebase inhibit. A `reg_wr` cycle loads all eight bits. `reg_rdata` shows the stored word in the cycle after the write.
- R3: An overflow pulse sets its flag (bits 4/5/6) whatever the enables are. If a write clears that flag in the same cycle, the pulse wins and the flag reads 1.
- R4: Requests are evaluated only in a cycle with `t2_rise`=1, and `call_req` rises one clock later. A flag set by a pulse in that same cycle waits for the next `t2_rise`.
- R5: The timebase is eligible when bits 0, 1 and 4 are 1 and bit 7 is 0. Sampler-1 is eligible when bits 0, 2 and 5 are 1. Sampler-2 is eligible when bits 0, 3 and 6 are 1.
- R6: If more than one source is eligible, only one call is raised. Timebase beats sampler-1, which beats sampler-2. The vectors are 0x04 (timebase), 0x08 (sampler-1) and 0x0C (sampler-2).
- R7: If `stack_full`=1 in the evaluation cycle, no call is raised and the flags are kept. The request is taken at a later `t2_rise` once `stack_full` is 0.
- R8: A raised call holds `call_req`=1 and an unchanged `call_vec` until `call_ack`. While it is outstanding, `t2_rise` and new flags do not change it.
- R9: `call_ack` with `call_req`=1 clears the served source's flag and the global enable (bit 0), and drops `call_req` on the next clock. Other bits keep their value. `call_ack` with `call_req`=0 changes nothing.
- R10: `reti_stb` sets the global enable on the next clock. Apart from a CPU write, nothing else sets it.
- R11: Inside a service routine, a software write that sets the global enable and a source enable lets a pending source be called at the next `t2_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control word |
| ovf_tb | input | 1 | Timebase overflow pulse |
| ovf_s1 | input | 1 | Sampler-1 overflow pulse |
| ovf_s2 | input | 1 | Sampler-2 overflow pulse |
| t2_rise | input | 1 | One-cycle strobe marking the evaluation edge |
| stack_full | input | 1 | CPU stack has no free entry |
| call_ack | input | 1 | CPU has taken the posted call |
| reti_stb | input | 1 | Return-from-interrupt executed |
| call_req | output | 1 | Vectored call posted |
| call_vec | output | 8 | Call target address |

## Verification
The hardest cases to reach from the ports are a request held back by a full stack and then released, and an overflow that lands exactly on a write clearing the same flag. Both need the inputs lined up to the cycle. The bench walks every one of the 256 control words, with the stack full and with it free. It writes each word directly, strobes `t2_rise`, computes the expected call and vector arithmetically, and then acknowledges the call and checks that only the right bits were cleared. Directed sequences then set up the collisions: a pulse together with a clearing write, a pulse together with `t2_rise`, new flags and strobes while a call is outstanding, and a stack that becomes free between two strobes.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared bit positions and sizes for the interrupt controller.
// Assumes exactly three sources. The word layout is fixed because software decodes it.
package irq_ctrl_pkg;
    localparam int NSRC   = 3;            // timebase, sampler-1, sampler-2
    localparam int REG_W  = 2 * NSRC + 2; // global enable + enables + flags + inhibit
    localparam int B_GEN  = 0;            // global enable
    localparam int B_EN0  = 1;            // first source enable
    localparam int B_FLG0 = B_EN0 + NSRC; // first source flag
    localparam int B_INH  = REG_W - 1;    // timebase inhibit
endpackage

// File: rtl/irq_ctl_reg.sv
// Module: control/flag word storage.
// Loads the whole word on a write. Overflow pulses set flags and win over the write.
// The acknowledge clears one flag and the global enable. The return strobe sets the
// global enable, and it wins over the acknowledge.
module irq_ctl_reg
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NSRC-1:0]  ovf,
    input  logic [NSRC-1:0]  flag_clr,
    input  logic             gen_clr,
    input  logic             gen_set,
    output logic [REG_W-1:0] ctl_q
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] flg_q;
    logic            gen_q;
    logic            inh_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Per-source enable: follows software writes only.
        always_ff @(posedge clk) begin
            if (!rst_n)     en_q[g] <= 1'b0;
            else if (wr_en) en_q[g] <= wr_data[B_EN0+g];
        end

        // Per-source flag: pulse sets it, acknowledge clears it, otherwise the write applies.
        always_ff @(posedge clk) begin
            if (!rst_n) flg_q[g] <= 1'b0;
            else        flg_q[g] <= ovf[g] |
                                    (~flag_clr[g] & (wr_en ? wr_data[B_FLG0+g] : flg_q[g]));
        end
    end

    // Global enable: the return strobe sets it, the acknowledge clears it, otherwise the write applies.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= 1'b0;
        else        gen_q <= gen_set | (~gen_clr & (wr_en ? wr_data[B_GEN] : gen_q));
    end

    // Timebase inhibit: follows software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)     inh_q <= 1'b0;
        else if (wr_en) inh_q <= wr_data[B_INH];
    end

    assign ctl_q = {inh_q, flg_q, en_q, gen_q};
endmodule

// File: rtl/irq_pick.sv
// Module: eligibility and fixed-priority selection, purely combinational.
// Source 0 (timebase) is also gated by the inhibit bit. The lowest index wins.
module irq_pick
    import irq_ctrl_pkg::*;
(
    input  logic [REG_W-1:0] ctl,
    output logic [NSRC-1:0]  win
);
    logic [NSRC-1:0] elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        if (g == 0) begin : g_tb
            assign elig[g] = ctl[B_GEN] & ctl[B_EN0+g] & ctl[B_FLG0+g] & ~ctl[B_INH];
        end else begin : g_smp
            assign elig[g] = ctl[B_GEN] & ctl[B_EN0+g] & ctl[B_FLG0+g];
        end
    end

    // Keep only the highest-priority eligible source.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            win[i] = elig[i] & ~taken;
            taken  = taken | elig[i];
        end
    end
endmodule

// File: rtl/irq_call_seq.sv
// Module: posts one vectored call per evaluation strobe and holds it until acknowledged.
// Assumes the CPU eventually acknowledges each posted call. No re-evaluation happens meanwhile.
module irq_call_seq
    import irq_ctrl_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [VEC_W-1:0] VEC_TB = 'h04,
    parameter logic [VEC_W-1:0] VEC_S1 = 'h08,
    parameter logic [VEC_W-1:0] VEC_S2 = 'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t2_rise,
    input  logic             stack_full,
    input  logic [NSRC-1:0]  win,
    input  logic             call_ack,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    output logic [NSRC-1:0]  flag_clr,
    output logic             gen_clr
);
    logic             req_q;
    logic [NSRC-1:0]  sel_q;
    logic [VEC_W-1:0] vec_q;
    logic             launch;
    logic             taken;
    logic [VEC_W-1:0] vec_d;

    assign launch = t2_rise & ~req_q & ~stack_full & (|win);
    assign taken  = req_q & call_ack;

    // Map the one-hot winner to its vector.
    always_comb begin
        if (win[0])      vec_d = VEC_TB;
        else if (win[1]) vec_d = VEC_S1;
        else             vec_d = VEC_S2;
    end

    // Post the call on launch and release it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            sel_q <= '0;
            vec_q <= '0;
        end else if (launch) begin
            req_q <= 1'b1;
            sel_q <= win;
            vec_q <= vec_d;
        end else if (taken) begin
            req_q <= 1'b0;
        end
    end

    assign call_req = req_q;
    assign call_vec = vec_q;
    assign flag_clr = taken ? sel_q : '0;
    assign gen_clr  = taken;
endmodule

// File: rtl/irq_ctrl.sv
// Module: top of the three-source vectored interrupt controller.
// Joins the word storage, the selector and the call sequencer. The CPU handles the stack
// and the program counter. stack_full and the strobes come in synchronous to clk.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [VEC_W-1:0] VEC_TB = 'h04,
    parameter logic [VEC_W-1:0] VEC_S1 = 'h08,
    parameter logic [VEC_W-1:0] VEC_S2 = 'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ovf_tb,
    input  logic             ovf_s1,
    input  logic             ovf_s2,
    input  logic             t2_rise,
    input  logic             stack_full,
    input  logic             call_ack,
    input  logic             reti_stb,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec
);
    logic [REG_W-1:0] ctl;
    logic [NSRC-1:0]  win;
    logic [NSRC-1:0]  flag_clr;
    logic             gen_clr;

    irq_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .ovf      ({ovf_s2, ovf_s1, ovf_tb}),
        .flag_clr (flag_clr),
        .gen_clr  (gen_clr),
        .gen_set  (reti_stb),
        .ctl_q    (ctl)
    );

    irq_pick u_pick (
        .ctl (ctl),
        .win (win)
    );

    irq_call_seq #(
        .VEC_W  (VEC_W),
        .VEC_TB (VEC_TB),
        .VEC_S1 (VEC_S1),
        .VEC_S2 (VEC_S2)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .t2_rise    (t2_rise),
        .stack_full (stack_full),
        .win        (win),
        .call_ack   (call_ack),
        .call_req   (call_req),
        .call_vec   (call_vec),
        .flag_clr   (flag_clr),
        .gen_clr    (gen_clr)
    );

    assign reg_rdata = ctl;
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: property checker bound to irq_ctrl. Sees only the top-level ports.
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             ovf_tb,
    input logic             ovf_s1,
    input logic             ovf_s2,
    input logic             t2_rise,
    input logic             stack_full,
    input logic             call_ack,
    input logic             reti_stb,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec
);
    // R4
    rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(t2_rise));

    // R7
    stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_rise && stack_full && !call_req) |=> !call_req);

    // R8
    call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_ack) |=> (call_req && $stable(call_vec)));

    // R6
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec == 'h04 || call_vec == 'h08 || call_vec == 'h0C));

    // R9
    ack_gen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_ack && !reti_stb) |=> (!reg_rdata[0] && !call_req));

    // R10
    reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti_stb |=> reg_rdata[0]);

    // R3
    ovf_tb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tb |=> reg_rdata[4]);

    // R3
    ovf_s2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_s2 |=> reg_rdata[6]);
endmodule

bind irq_ctrl irq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ovf_tb = 1'b0, ovf_s1 = 1'b0, ovf_s2 = 1'b0;
    logic       t2_rise = 1'b0, stack_full = 1'b0, call_ack = 1'b0, reti_stb = 1'b0;
    logic       call_req;
    logic [7:0] call_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    irq_ctrl u_irq_ctrl (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic strobe();
        t2_rise = 1'b1;
        cyc();
        t2_rise = 1'b0;
    endtask

    task automatic ack();
        call_ack = 1'b1;
        cyc();
        call_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 word", reg_rdata, 8'h00);
        check("R1 req", call_req, 0);
        check("R1 vec", call_vec, 8'h00);

        // R2 write and read back
        wr(8'hA5);
        check("R2 readback", reg_rdata, 8'hA5);
        wr(8'h00);

        // R5 R6 R7 R9 sweep over every word, stack full and free
        for (int v = 0; v < 256; v++) begin
            for (int sf = 0; sf < 2; sf++) begin
                logic [7:0] w;
                logic tb, s1, s2, ec;
                logic [7:0] ev;
                int cb;
                w  = v[7:0];
                tb = w[0] & w[1] & w[4] & ~w[7];
                s1 = w[0] & w[2] & w[5];
                s2 = w[0] & w[3] & w[6];
                ec = (sf == 0) & (tb | s1 | s2);
                ev = tb ? 8'h04 : (s1 ? 8'h08 : 8'h0C);
                cb = tb ? 4 : (s1 ? 5 : 6);
                wr(w);
                stack_full = (sf == 1);
                strobe();
                stack_full = 1'b0;
                check("R5/R7 call", call_req, ec);
                if (ec) begin
                    check("R6 vector", call_vec, ev);
                    ack();
                    check("R9 drop", call_req, 0);
                    check("R9 cleared", reg_rdata, w & ~(8'h01 << cb) & 8'hFE);
                end else begin
                    check("R7 flags kept", reg_rdata, w);
                end
            end
        end

        // R3 pulse sets a flag with everything disabled
        wr(8'h00);
        ovf_s2 = 1'b1; cyc(); ovf_s2 = 1'b0;
        check("R3 set", reg_rdata, 8'h40);
        strobe();
        check("R3 no call", call_req, 0);
        // R3 pulse beats a clearing write
        reg_wr = 1'b1; reg_wdata = 8'h00; ovf_s2 = 1'b1;
        cyc();
        reg_wr = 1'b0; ovf_s2 = 1'b0;
        check("R3 race", reg_rdata, 8'h40);

        // R4 pulse in the strobe cycle waits for the next strobe
        wr(8'h03);
        ovf_tb = 1'b1; t2_rise = 1'b1;
        cyc();
        ovf_tb = 1'b0; t2_rise = 1'b0;
        check("R4 same cycle", call_req, 0);
        check("R4 flag", reg_rdata, 8'h13);
        repeat (3) cyc();
        check("R4 no strobe", call_req, 0);
        strobe();
        check("R4 later", call_req, 1);
        check("R4 vec", call_vec, 8'h04);
        ack();
        check("R9 tb ack", reg_rdata, 8'h02);

        // R8 hold while pending
        wr(8'h27);
        strobe();
        check("R8 posted", call_vec, 8'h08);
        ovf_tb = 1'b1; t2_rise = 1'b1;
        repeat (4) cyc();
        ovf_tb = 1'b0; t2_rise = 1'b0;
        check("R8 req held", call_req, 1);
        check("R8 vec held", call_vec, 8'h08);
        ack();
        check("R9 s1 ack", reg_rdata, 8'h16);

        // R10 return strobe restores the global enable, then the timebase is taken
        reti_stb = 1'b1; cyc(); reti_stb = 1'b0;
        check("R10 reti", reg_rdata, 8'h17);
        strobe();
        check("R10 call", call_vec, 8'h04);
        ack();
        check("R10 no restore on ack", reg_rdata, 8'h06);

        // R11 nesting by software write inside the service routine
        wr(8'h45);
        strobe();
        check("R11 no emi", call_req, 0);
        wr(8'h4D);
        strobe();
        check("R11 nest", call_vec, 8'h0C);
        ack();

        // R7 stack full, then released between strobes
        wr(8'h49);
        stack_full = 1'b1;
        strobe();
        check("R7 blocked", call_req, 0);
        stack_full = 1'b0;
        repeat (2) cyc();
        check("R7 wait strobe", call_req, 0);
        strobe();
        check("R7 released", call_vec, 8'h0C);
        ack();
        check("R7 ack", reg_rdata, 8'h08);

        // R9 stray acknowledge has no effect
        wr(8'h31);
        ack();
        check("R9 stray", reg_rdata, 8'h31);
        check("R9 stray req", call_req, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule